// File: doc/BRIEF.md
# Parallel ADC Word Capture Interface

This block sits between a delta-sigma converter and the logic that uses its samples. The converter has its own clock. It announces each 16-bit two's-complement result by pulling an active-low ready strobe low, and it holds that word on a parallel bus. The block passes the strobe and every data line through two flip-flops clocked by the local clock. It detects the strobe's return to high and latches the word at that moment. The word is then offered with a single-cycle valid pulse.

The block also drives the converter's control pins from a small register that can be written at any time. These pins are a converter reset, an active-low chip select, an active-low read enable and a two-bit module address. The converter produces meaningless words while it settles after reset and while its bus is not driven. For that reason the block counts strobe returns once the converter is fully enabled. It suppresses the first 47 of them, and it starts the count again whenever the converter is disabled or put back into reset.

Top module: `adc_word_capture`

## Requirements
- R1: After local reset `conv_rst_n` is 0, `conv_cs_n` and `conv_rd_n` are 1, `conv_addr` is 0, `word_valid` is 0 and `word_out` is 0.
- R2: A cycle with `cfg_we` high loads `cfg_hold_rst` (1 holds the converter in reset, giving `conv_rst_n` = 0), `cfg_cs_n`, `cfg_rd_n` and `cfg_addr` onto the control outputs at the next clock edge. Without `cfg_we` the control outputs keep their value.
- R3: Suppose `conv_drdy_n` is first sampled high at clock edge k, after being sampled low at edge k-1, and the word is released. Then `word_valid` is high for exactly the one cycle after edge k+2.
- R4: The word presented is the bus value sampled at edge k-1, while the strobe was still low.
- R5: A falling edge of `conv_drdy_n` never produces a valid pulse.
- R6: The converter is enabled when `conv_rst_n`=1, `conv_cs_n`=0 and `conv_rd_n`=0. After it becomes enabled, the first 47 strobe returns produce no pulse, and the 48th and later ones do.
- R7: Putting the converter back into reset, or raising chip select or read enable, restarts the count of R6 from zero.
- R8: `word_out` changes only in a cycle where `word_valid` is high, and otherwise holds its last word.
- R9: Every 16-bit code passes unchanged, including the extremes 0x7FFF and 0x8000.
- R10: No valid pulse is produced while the converter is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Local active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for the control register |
| cfg_hold_rst | input | 1 | 1 holds the converter in reset |
| cfg_cs_n | input | 1 | Chip select value to load (active low) |
| cfg_rd_n | input | 1 | Read enable value to load (active low) |
| cfg_addr | input | 2 | Module address value to load |
| conv_data | input | 16 | Converter parallel data bus |
| conv_drdy_n | input | 1 | Converter active-low data-ready strobe |
| conv_rst_n | output | 1 | Converter reset, active low |
| conv_cs_n | output | 1 | Converter chip select, active low |
| conv_rd_n | output | 1 | Converter read enable, active low |
| conv_addr | output | 2 | Converter module address |
| word_out | output | 16 | Last captured word |
| word_valid | output | 1 | One-cycle pulse marking a new word |

## Verification
The hardest case to reach from the ports is the boundary of the settling window. The 47th strobe return after enabling must stay silent and the 48th must not, and that boundary has to be met a second time after a reset issued in mid-stream. The stimulus drives complete strobe periods with random data and a bench model of the settle count. It crosses the boundary once from a clean enable. It then re-asserts converter reset partway through a later run and crosses the boundary again.

// File: rtl/adc_word_capture.sv
module adc_word_capture #(
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 2,
  parameter int SETTLE_EDGES = 47,
  localparam int CNT_W       = $clog2(SETTLE_EDGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_hold_rst,
  input  logic              cfg_cs_n,
  input  logic              cfg_rd_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_drdy_n,
  output logic              conv_rst_n,
  output logic              conv_cs_n,
  output logic              conv_rd_n,
  output logic [ADDR_W-1:0] conv_addr,
  output logic [DATA_W-1:0] word_out,
  output logic              word_valid
);

  logic [1:0]        strb_sync;
  logic              strb_dly;
  logic [DATA_W-1:0] dat_s1, dat_s2, dat_s3;
  logic [CNT_W-1:0]  settle_cnt;

  wire strb_rise    = strb_sync[1] & ~strb_dly;
  wire conv_enabled = conv_rst_n & ~conv_cs_n & ~conv_rd_n;
  wire settled      = (settle_cnt == CNT_W'(SETTLE_EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_rst_n <= 1'b0;
      conv_cs_n  <= 1'b1;
      conv_rd_n  <= 1'b1;
      conv_addr  <= '0;
    end else if (cfg_we) begin
      conv_rst_n <= ~cfg_hold_rst;
      conv_cs_n  <= cfg_cs_n;
      conv_rd_n  <= cfg_rd_n;
      conv_addr  <= cfg_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_sync <= 2'b11;
      strb_dly  <= 1'b1;
      dat_s1    <= '0;
      dat_s2    <= '0;
      dat_s3    <= '0;
    end else begin
      strb_sync <= {strb_sync[0], conv_drdy_n};
      strb_dly  <= strb_sync[1];
      dat_s1    <= conv_data;
      dat_s2    <= dat_s1;
      dat_s3    <= dat_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      settle_cnt <= '0;
    else if (!conv_enabled)
      settle_cnt <= '0;
    else if (strb_rise && !settled)
      settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= strb_rise & settled & conv_enabled;
      if (strb_rise && settled && conv_enabled)
        word_out <= dat_s3;
    end
  end

endmodule

// File: rtl/adc_word_capture_chk.sv
module adc_word_capture_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_hold_rst,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] conv_data,
  input logic              conv_drdy_n,
  input logic              conv_rst_n,
  input logic              conv_cs_n,
  input logic              conv_rd_n,
  input logic [ADDR_W-1:0] conv_addr,
  input logic [DATA_W-1:0] word_out,
  input logic              word_valid
);

  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (conv_addr == $past(cfg_addr)) && (conv_rst_n == !$past(cfg_hold_rst)));

  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(conv_addr) && $stable(conv_cs_n) && $stable(conv_rd_n) && $stable(conv_rst_n));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  a_r5_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(conv_drdy_n, 3) && !$past(conv_drdy_n, 4));

  a_r4_word_match: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_out == $past(conv_data, 4));

  a_r8_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_out));

  a_r10_no_valid_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_rst_n || conv_cs_n || conv_rd_n) |=> !word_valid);

endmodule

bind adc_word_capture adc_word_capture_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hold_rst(cfg_hold_rst),
  .cfg_addr(cfg_addr), .conv_data(conv_data), .conv_drdy_n(conv_drdy_n),
  .conv_rst_n(conv_rst_n), .conv_cs_n(conv_cs_n), .conv_rd_n(conv_rd_n),
  .conv_addr(conv_addr), .word_out(word_out), .word_valid(word_valid)
);

// File: tb/tb_adc_word_capture.sv
module tb_adc_word_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_hold_rst = 1'b1, cfg_cs_n = 1'b1, cfg_rd_n = 1'b1;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] conv_data = 16'd0;
  logic        conv_drdy_n = 1'b1;
  logic        conv_rst_n, conv_cs_n, conv_rd_n, word_valid;
  logic [1:0]  conv_addr;
  logic [15:0] word_out;

  int compared = 0, mismatched = 0;
  int settle = 0;
  bit en_m = 0;
  logic [15:0] last_word = 16'd0;

  always #2.5 clk = ~clk;

  adc_word_capture dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hold_rst(cfg_hold_rst),
    .cfg_cs_n(cfg_cs_n), .cfg_rd_n(cfg_rd_n), .cfg_addr(cfg_addr),
    .conv_data(conv_data), .conv_drdy_n(conv_drdy_n), .conv_rst_n(conv_rst_n),
    .conv_cs_n(conv_cs_n), .conv_rd_n(conv_rd_n), .conv_addr(conv_addr),
    .word_out(word_out), .word_valid(word_valid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expect_valid();
    if (!en_m) return 0;
    if (settle == 47) return 1;
    settle++;
    return 0;
  endfunction

  task automatic write_ctrl(bit hold, bit cs, bit rd, logic [1:0] a);
    @(negedge clk);
    cfg_we = 1; cfg_hold_rst = hold; cfg_cs_n = cs; cfg_rd_n = rd; cfg_addr = a;
    @(negedge clk);
    cfg_we = 0;
    en_m = !hold && !cs && !rd;
    if (!en_m) settle = 0;
    check("R2 ctrl", {conv_rst_n, conv_cs_n, conv_rd_n, conv_addr}, {!hold, cs, rd, a});
    repeat (2) @(negedge clk);
    check("R2 hold", {conv_rst_n, conv_cs_n, conv_rd_n, conv_addr}, {!hold, cs, rd, a});
  endtask

  task automatic frame(logic [15:0] d, string req);
    bit exp_v, spurious;
    spurious = 0;
    @(negedge clk);
    conv_drdy_n = 0; conv_data = d;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (word_valid) spurious = 1;
    end
    conv_drdy_n = 1;
    exp_v = expect_valid();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (word_valid) spurious = 1;
    end
    @(negedge clk);
    check({req, " R3 valid"}, word_valid, exp_v);
    if (exp_v) begin
      check({req, " R4 word"}, word_out, d);
      last_word = d;
    end else
      check({req, " R8 hold"}, word_out, last_word);
    @(negedge clk);
    if (word_valid) spurious = 1;
    check("R5 no pulse off the rise edge", spurious, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2011));
    repeat (3) @(negedge clk);
    check("R1 ctrl", {conv_rst_n, conv_cs_n, conv_rd_n, conv_addr}, 5'b01100);
    check("R1 out", {word_valid, word_out}, 17'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 after release", {word_valid, word_out}, 17'd0);
    for (int i = 0; i < 3; i++) frame(16'(32'h1111 * (i + 1)), "R10 in reset");
    write_ctrl(0, 1, 0, 2'd1);
    for (int i = 0; i < 3; i++) frame(16'($urandom), "R10 cs high");
    write_ctrl(0, 0, 0, 2'd2);
    for (int i = 0; i < 47; i++) frame(16'($urandom), "R6 settling");
    frame(16'h7FFF, "R6 first R9 max");
    frame(16'h8000, "R9 min");
    frame(16'h0000, "R9 zero");
    frame(16'hFFFF, "R9 minus one");
    for (int i = 0; i < 10; i++) frame(16'($urandom), "R4 random");
    write_ctrl(0, 0, 1, 2'd2);
    for (int i = 0; i < 3; i++) frame(16'($urandom), "R10 rd high R8");
    write_ctrl(0, 0, 0, 2'd3);
    for (int i = 0; i < 20; i++) frame(16'($urandom), "R7 partial");
    write_ctrl(1, 0, 0, 2'd3);
    frame(16'h1234, "R7 R10 reset again");
    write_ctrl(0, 0, 0, 2'd3);
    for (int i = 0; i < 47; i++) frame(16'($urandom), "R7 resettle");
    for (int i = 0; i < 5; i++) frame(16'($urandom), "R7 after resettle");
    finish_run();
  end
endmodule